// File: doc/BRIEF.md
# Programmable Interval Timer with Prescaler and Alarm

The block is a general-purpose timer for a peripheral subsystem. A 16-bit prescaler divides the bus clock into count ticks. Each tick moves a 64-bit counter up or down by one. Software programs it through a simple word-wide register port with byte addresses. Every write completes in the cycle it is presented, and read data is combinational from the address.

Software reads the counter by requesting a snapshot and waiting for hardware to acknowledge it. It reloads the counter by staging a 64-bit value and then writing a trigger register. An alarm comparator watches the low 54 counter bits. On a match it raises a level interrupt, disarms itself, and can make the counter restart from the staged value. The interrupt has raw, enable and write-one-to-clear registers.

Register map (byte offsets): 0x00 control, 0x04 snapshot request, 0x08/0x0C snapshot low/high, 0x10/0x14 staged value low/high, 0x18 reload trigger, 0x1C/0x20 alarm low/high, 0x24 interrupt raw, 0x28 interrupt enable, 0x2C interrupt clear.

Top module: `gp_timer`

## Requirements
- R1: The divider field is control bits [31:16]. Field 0 divides by 65536, fields 1 and 2 both divide by 2, and any other value N divides by N. After the counter is started, it has moved by floor(cycles/divisor) ticks.
- R2: Each tick adds one to the counter when control bit 1 is 1 and subtracts one when it is 0. The counter wraps modulo 2^64.
- R3: While control bit 0 (run) is 0, neither the counter nor the prescaler advances.
- R4: Writing 1 to bit 0 of 0x04 sets that bit. On the next clock, hardware copies the counter into 0x08 (bits 31:0) and 0x0C (bits 63:32) and clears the bit. Writing 0 to 0x04 changes nothing.
- R5: 0x10 and 0x14 hold the low and high staged words and read back. Any write to 0x18 copies the 64-bit staged value into the counter.
- R6: 0x1C holds alarm bits 31:0. 0x20 keeps only its bits [21:0] as alarm bits 53:32, and reads its bits [31:22] as 0.
- R7: While control bit 3 (arm) is 1 and counter bits [53:0] equal the alarm value, interrupt raw (0x24 bit 0) sets and arm clears on the same edge. Counter bits 63:54 are not compared.
- R8: If control bit 2 (auto-reload) is 1 at an alarm match, the next tick loads the staged value instead of advancing.
- R9: Output irq equals raw AND enable (0x28 bit 0). It stays asserted until raw is cleared.
- R10: Writing 1 to bit 0 of 0x2C clears raw. Writing 0 leaves raw unchanged.
- R11: Every write to the control register restarts the prescaler phase from zero.
- R12: Control bits 4 (level select) and 5 (clock select) are stored and read back, and have no effect on counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 8 | Byte address of the accessed register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| irq | output | 1 | Level interrupt, raw AND enable |

## Verification
The embedded properties assume a divisor of at least two, so ticks are never back to back. They also assume that an alarm match is decided by counter state alone, regardless of any control write in the same cycle. The stimulus keeps every divider field within its encoded range. Measured run windows are bounded by two control writes a known number of edges apart, and alarms are armed only while no snapshot or reload request is pending. Random trials draw divider, direction, start value and the two inert control bits from a fixed seed. Directed cases cover the divide-by-65536 and divide-by-2 encodings, wrap in both directions, alarm with and without auto-reload, and interrupt masking and clearing.

// File: rtl/gp_timer_pkg.sv
package gp_timer_pkg;
   localparam logic [7:0] A_CTRL    = 8'h00;
   localparam logic [7:0] A_SNAPREQ = 8'h04;
   localparam logic [7:0] A_SNAPLO  = 8'h08;
   localparam logic [7:0] A_SNAPHI  = 8'h0C;
   localparam logic [7:0] A_STGLO   = 8'h10;
   localparam logic [7:0] A_STGHI   = 8'h14;
   localparam logic [7:0] A_RELOAD  = 8'h18;
   localparam logic [7:0] A_ALMLO   = 8'h1C;
   localparam logic [7:0] A_ALMHI   = 8'h20;
   localparam logic [7:0] A_IRAW    = 8'h24;
   localparam logic [7:0] A_IEN     = 8'h28;
   localparam logic [7:0] A_ICLR    = 8'h2C;

   localparam int B_RUN  = 0;
   localparam int B_UP   = 1;
   localparam int B_ARL  = 2;
   localparam int B_ARM  = 3;
   localparam int B_LVL  = 4;
   localparam int B_CSEL = 5;
   localparam int DIV_LSB = 16;

   typedef struct packed {
      logic run;
      logic up;
      logic arl;
      logic arm;
      logic lvl;
      logic csel;
   } ctrl_t;
endpackage

// File: rtl/gp_timer_prescaler.sv
module gp_timer_prescaler #(
   parameter int DIV_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             restart,
   input  logic [DIV_W-1:0] div_field,
   output logic             tick
);
   logic [DIV_W-1:0] phase;
   logic [DIV_W-1:0] term;

   if (DIV_W < 2) begin : g_bad_div
      $error("gp_timer_prescaler: DIV_W must be at least 2");
   end

   // Field 0 -> full range, 1 and 2 -> divide by two, else divide by field
   always_comb begin
      if (div_field == '0)
         term = '1;
      else if (div_field <= DIV_W'(2))
         term = DIV_W'(1);
      else
         term = div_field - DIV_W'(1);
   end

   assign tick = run && (phase == term);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         phase <= '0;
      else if (restart)
         phase <= '0;
      else if (run)
         phase <= tick ? '0 : phase + DIV_W'(1);
   end

   // R1: the smallest divisor is two, so ticks never come back to back
   p_tick_spacing_r1: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick);

   // R3: a stopped prescaler keeps its phase
   p_phase_frozen_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !restart) |=> $stable(phase));
endmodule

// File: rtl/gp_timer_counter.sv
module gp_timer_counter #(
   parameter int CNT_W = 64
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             up,
   input  logic             load_go,
   input  logic [CNT_W-1:0] stage_val,
   input  logic             hit,
   input  logic             reload_en,
   output logic [CNT_W-1:0] cnt
);
   logic pend;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt  <= '0;
         pend <= 1'b0;
      end else begin
         if (load_go) begin
            cnt  <= stage_val;
            pend <= 1'b0;
         end else if (tick) begin
            if (pend) begin
               cnt  <= stage_val;
               pend <= 1'b0;
            end else begin
               cnt <= up ? cnt + CNT_W'(1) : cnt - CNT_W'(1);
            end
         end
         if (hit && reload_en && !load_go)
            pend <= 1'b1;
      end
   end

   // R3: without a tick or a software reload the count holds
   p_count_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !load_go) |=> cnt == $past(cnt));

   // R2: an up tick adds exactly one
   p_count_up_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !load_go && !pend && up) |=> cnt == $past(cnt) + CNT_W'(1));

   // R8: a pending auto-reload replaces the step with the staged value
   p_auto_reload_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && pend && !load_go) |=> cnt == $past(stage_val));

   // R5: the reload trigger copies the staged value
   p_sw_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
      load_go |=> cnt == $past(stage_val));
endmodule

// File: rtl/gp_timer_alarm.sv
module gp_timer_alarm #(
   parameter int CNT_W = 64,
   parameter int ALM_W = 54
) (
   input  logic             arm,
   input  logic [CNT_W-1:0] cnt,
   input  logic [ALM_W-1:0] alarm,
   output logic             hit
);
   if (ALM_W > CNT_W) begin : g_bad_alm
      $error("gp_timer_alarm: ALM_W exceeds CNT_W");
   end

   if (ALM_W == CNT_W) begin : g_full
      assign hit = arm && (cnt == alarm);
   end else begin : g_part
      assign hit = arm && (cnt[ALM_W-1:0] == alarm);
   end
endmodule

// File: rtl/gp_timer.sv
module gp_timer
   import gp_timer_pkg::*;
#(
   parameter int CNT_W  = 64,
   parameter int ALM_W  = 54,
   parameter int DIV_W  = 16,
   parameter int ADDR_W = 8,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              irq
);
   localparam int HI_W     = CNT_W - DATA_W;
   localparam int ALM_HI_W = ALM_W - DATA_W;

   if (DATA_W != 32 || HI_W != DATA_W) begin : g_bad_width
      $error("gp_timer: requires 32-bit data and a 64-bit counter");
   end
   if (ALM_HI_W < 1 || ALM_HI_W > DATA_W) begin : g_bad_alm
      $error("gp_timer: alarm width must lie between the two words");
   end
   if (DIV_W > DATA_W - DIV_LSB || ADDR_W < 6) begin : g_bad_field
      $error("gp_timer: divider field or address too wide/narrow");
   end

   ctrl_t            ctl;
   logic [DIV_W-1:0] div_field;
   logic             snap_req;
   logic [CNT_W-1:0] snap;
   logic [CNT_W-1:0] stage_val;
   logic [ALM_W-1:0] alarm;
   logic             raw, ien;
   logic [CNT_W-1:0] cnt;
   logic             tick, hit;

   logic wr_ctrl, wr_sreq, wr_slo, wr_shi, wr_go, wr_alo, wr_ahi, wr_ien, wr_clr;
   assign wr_ctrl = reg_wr && reg_addr == ADDR_W'(A_CTRL);
   assign wr_sreq = reg_wr && reg_addr == ADDR_W'(A_SNAPREQ);
   assign wr_slo  = reg_wr && reg_addr == ADDR_W'(A_STGLO);
   assign wr_shi  = reg_wr && reg_addr == ADDR_W'(A_STGHI);
   assign wr_go   = reg_wr && reg_addr == ADDR_W'(A_RELOAD);
   assign wr_alo  = reg_wr && reg_addr == ADDR_W'(A_ALMLO);
   assign wr_ahi  = reg_wr && reg_addr == ADDR_W'(A_ALMHI);
   assign wr_ien  = reg_wr && reg_addr == ADDR_W'(A_IEN);
   assign wr_clr  = reg_wr && reg_addr == ADDR_W'(A_ICLR);

   gp_timer_prescaler #(.DIV_W(DIV_W)) u_pre (
      .clk(clk), .rst_n(rst_n), .run(ctl.run), .restart(wr_ctrl),
      .div_field(div_field), .tick(tick));

   gp_timer_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .tick(tick), .up(ctl.up), .load_go(wr_go),
      .stage_val(stage_val), .hit(hit), .reload_en(ctl.arl), .cnt(cnt));

   gp_timer_alarm #(.CNT_W(CNT_W), .ALM_W(ALM_W)) u_alm (
      .arm(ctl.arm), .cnt(cnt), .alarm(alarm), .hit(hit));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl       <= '0;
         div_field <= '0;
         snap_req  <= 1'b0;
         snap      <= '0;
         stage_val <= '0;
         alarm     <= '0;
         raw       <= 1'b0;
         ien       <= 1'b0;
      end else begin
         if (wr_ctrl) begin
            ctl.run   <= reg_wdata[B_RUN];
            ctl.up    <= reg_wdata[B_UP];
            ctl.arl   <= reg_wdata[B_ARL];
            ctl.arm   <= reg_wdata[B_ARM];
            ctl.lvl   <= reg_wdata[B_LVL];
            ctl.csel  <= reg_wdata[B_CSEL];
            div_field <= reg_wdata[DIV_LSB +: DIV_W];
         end else if (hit) begin
            ctl.arm <= 1'b0;
         end

         if (snap_req) begin
            snap     <= cnt;
            snap_req <= 1'b0;
         end else if (wr_sreq && reg_wdata[0]) begin
            snap_req <= 1'b1;
         end

         if (wr_slo) stage_val[DATA_W-1:0]     <= reg_wdata;
         if (wr_shi) stage_val[CNT_W-1:DATA_W] <= reg_wdata[HI_W-1:0];
         if (wr_alo) alarm[DATA_W-1:0]         <= reg_wdata;
         if (wr_ahi) alarm[ALM_W-1:DATA_W]     <= reg_wdata[ALM_HI_W-1:0];
         if (wr_ien) ien                       <= reg_wdata[0];

         if (hit)
            raw <= 1'b1;
         else if (wr_clr && reg_wdata[0])
            raw <= 1'b0;
      end
   end

   assign irq = raw & ien;

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         ADDR_W'(A_CTRL): begin
            reg_rdata[B_RUN]  = ctl.run;
            reg_rdata[B_UP]   = ctl.up;
            reg_rdata[B_ARL]  = ctl.arl;
            reg_rdata[B_ARM]  = ctl.arm;
            reg_rdata[B_LVL]  = ctl.lvl;
            reg_rdata[B_CSEL] = ctl.csel;
            reg_rdata[DIV_LSB +: DIV_W] = div_field;
         end
         ADDR_W'(A_SNAPREQ): reg_rdata[0] = snap_req;
         ADDR_W'(A_SNAPLO):  reg_rdata = snap[DATA_W-1:0];
         ADDR_W'(A_SNAPHI):  reg_rdata = snap[CNT_W-1:DATA_W];
         ADDR_W'(A_STGLO):   reg_rdata = stage_val[DATA_W-1:0];
         ADDR_W'(A_STGHI):   reg_rdata = stage_val[CNT_W-1:DATA_W];
         ADDR_W'(A_ALMLO):   reg_rdata = alarm[DATA_W-1:0];
         ADDR_W'(A_ALMHI):   reg_rdata[ALM_HI_W-1:0] = alarm[ALM_W-1:DATA_W];
         ADDR_W'(A_IRAW):    reg_rdata[0] = raw;
         ADDR_W'(A_IEN):     reg_rdata[0] = ien;
         default:            reg_rdata = '0;
      endcase
   end

   // R4: a pending snapshot completes on the next edge with the live count
   p_snapshot_r4: assert property (@(posedge clk) disable iff (!rst_n)
      snap_req |=> (!snap_req && snap == $past(cnt)));

   // R7: a match latches raw and disarms the alarm
   p_alarm_hit_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && !wr_ctrl) |=> (raw && !ctl.arm));

   // R10: a clear with bit 0 set and no new match drops raw
   p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_clr && reg_wdata[0] && !hit) |=> !raw);

   // R10: without a match, a clear write with bit 0 low keeps raw
   p_clear_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_clr && !reg_wdata[0] && !hit) |=> raw == $past(raw));
endmodule

// File: tb/gp_timer_tb.sv
module gp_timer_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [7:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        irq;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   always #10 clk = ~clk;

   gp_timer u_dut (.clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
                   .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq));

   localparam logic [7:0] CTRL = 8'h00, SREQ = 8'h04, SLO = 8'h08, SHI = 8'h0C,
                          LLO = 8'h10, LHI = 8'h14, LGO = 8'h18, ALO = 8'h1C,
                          AHI = 8'h20, IRAW = 8'h24, IEN = 8'h28, ICLR = 8'h2C;

   function automatic longint unsigned divisor(input logic [15:0] f);
      if (f == 16'd0) return 65536;
      if (f <= 16'd2) return 2;
      return longint'(f);
   endfunction

   function automatic logic [63:0] after_ticks(input logic [63:0] s, input bit up,
                                               input longint unsigned k);
      return up ? s + 64'(k) : s - 64'(k);
   endfunction

   function automatic logic [31:0] ctrl_word(input logic [15:0] f, input bit csel,
         input bit lvl, input bit arm, input bit arl, input bit up, input bit run);
      return {f, 10'd0, csel, lvl, arm, arl, up, run};
   endfunction

   task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s got=%h exp=%h", req, got, exp);
      end
   endtask

   // all tasks start and end at a falling edge
   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic snapshot(output logic [63:0] v);
      logic [31:0] s, lo, hi;
      wr(SREQ, 32'd1);
      for (int i = 0; i < 4; i++) begin
         rd(SREQ, s);
         if (s[0] == 1'b0) break;
         @(negedge clk);
      end
      check("R4 snapshot request cleared", 64'(s[0]), 64'd0);
      rd(SLO, lo);
      rd(SHI, hi);
      v = {hi, lo};
   endtask

   task automatic load64(input logic [63:0] v);
      wr(LLO, v[31:0]);
      wr(LHI, v[63:32]);
      wr(LGO, 32'h0);
   endtask

   // start at edge 0, stop at edge n: exactly n running edges
   task automatic run_for(input logic [31:0] on, input int n);
      wr(CTRL, on);
      repeat (n - 1) @(negedge clk);
      wr(CTRL, on & ~32'h9);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         bad++;
         total++;
         $display("FAIL watchdog expired");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [31:0] r;
      logic [63:0] v;
      void'($urandom(32'd20240331));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // reset state
      rd(CTRL, r);  check("R3 reset control", 64'(r), 64'd0);
      rd(IRAW, r);  check("R9 reset raw", 64'(r), 64'd0);
      check("R9 reset irq", 64'(irq), 64'd0);
      snapshot(v);  check("R4 reset count", v, 64'd0);

      // R5 staged value read back and reload
      wr(LLO, 32'hDEAD_BEEF); wr(LHI, 32'h0123_4567);
      rd(LLO, r); check("R5 staged low", 64'(r), 64'hDEAD_BEEF);
      rd(LHI, r); check("R5 staged high", 64'(r), 64'h0123_4567);
      wr(LGO, 32'h0);
      snapshot(v); check("R5 reload", v, 64'h0123_4567_DEAD_BEEF);

      // R4 writing 0 to the request has no effect
      load64(64'h55);
      wr(SREQ, 32'd0);
      rd(SREQ, r); check("R4 zero write leaves request clear", 64'(r), 64'd0);
      rd(SLO, r);  check("R4 zero write keeps snapshot", 64'(r), 64'hDEAD_BEEF);

      // R1 divisor encodings 1, 2 and 0
      load64(64'd0);
      run_for(ctrl_word(16'd1, 0, 0, 0, 0, 1, 1), 11);
      snapshot(v); check("R1 field 1 divides by 2", v, 64'd5);
      load64(64'd0);
      run_for(ctrl_word(16'd2, 0, 0, 0, 0, 1, 1), 11);
      snapshot(v); check("R1 field 2 divides by 2", v, 64'd5);
      load64(64'd0);
      run_for(ctrl_word(16'd0, 0, 0, 0, 0, 1, 1), 65546);
      snapshot(v); check("R1 field 0 divides by 65536", v, 64'd1);

      // R2 wrap in both directions
      load64(64'hFFFF_FFFF_FFFF_FFFF);
      run_for(ctrl_word(16'd2, 0, 0, 0, 0, 1, 1), 6);
      snapshot(v); check("R2 upward wrap", v, 64'd2);
      load64(64'd0);
      run_for(ctrl_word(16'd2, 0, 0, 0, 0, 0, 1), 6);
      snapshot(v); check("R2 downward wrap", v, 64'hFFFF_FFFF_FFFF_FFFD);

      // R3 stopped counter stays frozen
      repeat (50) @(negedge clk);
      snapshot(v); check("R3 frozen while stopped", v, 64'hFFFF_FFFF_FFFF_FFFD);

      // R11 control rewrite restarts the prescaler phase
      load64(64'd0);
      wr(CTRL, ctrl_word(16'd10, 0, 0, 0, 0, 1, 1));
      repeat (6) @(negedge clk);
      wr(CTRL, ctrl_word(16'd10, 0, 0, 0, 0, 1, 1));
      repeat (6) @(negedge clk);
      wr(CTRL, ctrl_word(16'd10, 0, 0, 0, 0, 1, 0));
      snapshot(v); check("R11 phase restarted on control write", v, 64'd0);

      // random trials: R1 R2 R12
      for (int i = 0; i < 6; i++) begin
         logic [15:0] f;
         int n;
         bit up, cs, lv;
         logic [63:0] s;
         f  = 16'($urandom_range(1, 40));
         n  = int'($urandom_range(20, 300));
         up = 1'($urandom_range(0, 1));
         cs = 1'($urandom_range(0, 1));
         lv = 1'($urandom_range(0, 1));
         s  = {$urandom, $urandom};
         load64(s);
         run_for(ctrl_word(f, cs, lv, 0, 0, up, 1), n);
         rd(CTRL, r);
         check("R12 inert bits stored", 64'(r), 64'(ctrl_word(f, cs, lv, 0, 0, up, 0)));
         snapshot(v);
         check("R1 R2 random count", v,
               after_ticks(s, up, longint'(n) / divisor(f)));
      end

      // R6 alarm high word keeps 22 bits
      wr(AHI, 32'hFFFF_FFFF);
      rd(AHI, r); check("R6 alarm high masked", 64'(r), 64'h003F_FFFF);

      // R7 alarm without reload; high word upper bits ignored
      wr(IEN, 32'd0);
      wr(ALO, 32'd105);
      wr(AHI, 32'hFFC0_0000);
      load64(64'd100);
      run_for(ctrl_word(16'd3, 0, 0, 1, 0, 1, 1), 60);
      rd(IRAW, r); check("R7 raw set on match", 64'(r), 64'd1);
      rd(CTRL, r); check("R7 arm cleared by match", 64'(r[3]), 64'd0);
      snapshot(v); check("R7 no reload keeps counting", v, 64'd120);
      check("R9 irq masked", 64'(irq), 64'd0);
      wr(IEN, 32'd1);
      check("R9 irq follows raw and enable", 64'(irq), 64'd1);

      // R10 clear semantics
      wr(ICLR, 32'd0);
      rd(IRAW, r); check("R10 zero write keeps raw", 64'(r), 64'd1);
      check("R9 irq held", 64'(irq), 64'd1);
      wr(ICLR, 32'd1);
      rd(IRAW, r); check("R10 one write clears raw", 64'(r), 64'd0);
      check("R9 irq drops after clear", 64'(irq), 64'd0);

      // R8 auto-reload on match
      wr(ALO, 32'd60);
      wr(AHI, 32'd0);
      load64(64'd50);
      run_for(ctrl_word(16'd2, 0, 0, 1, 1, 1, 1), 40);
      snapshot(v); check("R8 reload after match", v, 64'd59);
      check("R8 irq asserted", 64'(irq), 64'd1);

      // R7 bits above 53 are not compared
      wr(ICLR, 32'd1);
      wr(ALO, 32'd10);
      wr(AHI, 32'd0);
      load64(64'hFFC0_0000_0000_0008);
      run_for(ctrl_word(16'd2, 0, 0, 1, 0, 1, 1), 8);
      rd(IRAW, r); check("R7 match ignores top bits", 64'(r), 64'd1);

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule